// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable synchronous static RAM with a small on-chip array and a bus protocol that never needs an idle cycle when traffic turns from reads to writes. Every command is taken at a rising clock edge. A command is an address with read or write intent, or an advance request that steps a four-beat burst. Write data follows its command late, by the same number of cycles as read data. Reads and writes can therefore be issued every cycle in any mix, and the data bus stays busy without dead cycles.

A strap picks flow-through mode, with one cycle of latency, or pipelined mode, where read data leaves through an output register one cycle later. Writes that have been accepted but whose data has not yet arrived wait in a short late-write pipeline. A read of such an address sees the newer bytes. The array is split into 9-bit byte lanes, each written only when its byte enable is active. Parity of each written byte is checked against an even/odd setting, and the result is reported on a per-byte flag. Output enable and sleep gate the output drive without waiting for a clock.

Top module: `zt_sram`

## Requirements
- R1: A read accepted at edge E has its word on `dout` with `q_drive` high from just after edge E in flow-through mode (`pipe_mode`=0), and from just after edge E+1 in pipelined mode (`pipe_mode`=1), for one cycle.
- R2: For a write accepted at edge E, `din` is captured at edge E+1 in flow-through mode and at edge E+2 in pipelined mode, and later reads of that address return it.
- R3: Commands may alternate read and write every cycle. A read whose address matches a write still waiting for its data returns the newest data for each byte enabled by those writes, and array contents for the other bytes.
- R4: A new command is accepted only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0 at an edge with `adv`=0. Otherwise that edge neither writes nor produces read data.
- R5: Byte lane b is bits 9b+8 down to 9b. A write stores lane b only when `ben_n[b]`=0 at the command edge.
- R6: A command edge presets a burst from `addr`. Each following edge with `adv`=1 repeats the same read or write intent at the next beat, ignoring chip enables, `we_n` and `addr`. The upper address bits stay fixed. With `ilv_order`=0 the low two bits of beat k are (start+k) mod 4.
- R7: With `ilv_order`=1 the low two bits of beat k are start XOR k.
- R8: `oe_n`=1 forces `q_drive` low and `dout` to zero at once, without a clock edge.
- R9: An edge with `sleep`=1 accepts no command (no write, no read data), and while `sleep` is high `q_drive` is low.
- R10: After the edge that captures write data, `par_err[b]` is high for one cycle when lane b is enabled, `byte8_mode`=0, and the XOR of the lane's 9 bits differs from `par_odd`. The data is written regardless.
- R11: With `byte8_mode`=1, `par_err` stays zero and bit 8 of every written lane is stored as zero.
- R12: After a cycle with `rst` high, `q_drive` is low, `par_err` is zero and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pipe_mode | input | 1 | Strap: 1 pipelined, 0 flow-through |
| ilv_order | input | 1 | Strap: 1 interleaved burst, 0 linear |
| byte8_mode | input | 1 | Strap: 1 eight-bit bytes, 0 nine-bit bytes with parity |
| par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write intent, active low |
| adv | input | 1 | Advance the current burst |
| addr | input | AW | Word address; low two bits preset the burst |
| ben_n | input | NB | Byte write enables, active low |
| din | input | 9*NB | Late write data |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Power-down request, active high |
| dout | output | 9*NB | Read data, zero when not driven |
| q_drive | output | 1 | High while `dout` carries valid read data |
| par_err | output | NB | Per-lane write parity error flags |

## Verification
The checker takes the three straps as fixed between resets, since a change of `pipe_mode` while a write waits would move its data capture edge. The stimulus therefore sets the straps only while reset is held and drains the pipeline with idle cycles before the next reset. The checker also takes `oe_n` and `sleep` as free-running levels. The bench changes them only away from the clock edge. Sleep is never asserted in the cycle where it would also hide a read result that the bench intends to compare.

// File: rtl/zt_pkg.sv
package zt_pkg;

  localparam int LANE_W = 9;

  // low two address bits of burst beat idx
  function automatic logic [1:0] beat_lsb(input logic [1:0] start,
                                         input logic [1:0] idx,
                                         input logic       ilv);
    return ilv ? (start ^ idx) : (start + idx);
  endfunction

  // high when the lane does not have the requested parity sense
  function automatic logic lane_bad(input logic [LANE_W-1:0] v,
                                    input logic              odd);
    return (^v) ^ odd;
  endfunction

endpackage

// File: rtl/zt_ctrl.sv
module zt_ctrl #(
  parameter int AW = 8,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep,
  input  logic          adv,
  input  logic          cs1_n,
  input  logic          cs2,
  input  logic          cs3_n,
  input  logic          we_n,
  input  logic          ilv,
  input  logic [AW-1:0] addr_in,
  input  logic [NB-1:0] ben_n,
  output logic          cmd_vld,
  output logic          cmd_wr,
  output logic [AW-1:0] cmd_addr,
  output logic [NB-1:0] cmd_ben
);
  import zt_pkg::*;

  localparam int UW = AW - 2;

  logic          bst_act;
  logic          bst_wr;
  logic [UW-1:0] bst_base;
  logic [1:0]    bst_start;
  logic [1:0]    bst_cnt;
  logic [1:0]    cnt_nxt;
  logic          sel;
  logic          step;
  logic          load;

  assign sel     = ~cs1_n & cs2 & ~cs3_n;
  assign cnt_nxt = bst_cnt + 2'd1;
  assign step    = ~sleep & adv & bst_act;
  assign load    = ~sleep & ~adv & sel;

  always_comb begin
    cmd_vld  = 1'b0;
    cmd_wr   = 1'b0;
    cmd_addr = addr_in;
    cmd_ben  = ~ben_n;
    if (step) begin
      cmd_vld  = 1'b1;
      cmd_wr   = bst_wr;
      cmd_addr = {bst_base, beat_lsb(bst_start, cnt_nxt, ilv)};
    end else if (load) begin
      cmd_vld  = 1'b1;
      cmd_wr   = ~we_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bst_act   <= 1'b0;
      bst_wr    <= 1'b0;
      bst_base  <= '0;
      bst_start <= '0;
      bst_cnt   <= '0;
    end else if (!sleep) begin
      if (step) begin
        bst_cnt <= cnt_nxt;
      end else if (load) begin
        bst_act   <= 1'b1;
        bst_wr    <= ~we_n;
        bst_base  <= addr_in[AW-1:2];
        bst_start <= addr_in[1:0];
        bst_cnt   <= 2'd0;
      end else begin
        bst_act <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/zt_lane.sv
module zt_lane #(
  parameter int AW = 8,
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [LW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [LW-1:0] mem [DEPTH];

  // read-first single clock RAM, block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/zt_parity.sv
module zt_parity #(
  parameter int NB = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        chk_en,
  input  logic                        odd,
  input  logic [NB-1:0]               ben,
  input  logic [NB*zt_pkg::LANE_W-1:0] data,
  output logic [NB-1:0]               err
);
  import zt_pkg::*;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) err[b] <= 1'b0;
      else     err[b] <= chk_en & ben[b] & lane_bad(data[b*LANE_W +: LANE_W], odd);
    end
  end

endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW = 8,
  parameter int NB = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pipe_mode,
  input  logic                         ilv_order,
  input  logic                         byte8_mode,
  input  logic                         par_odd,
  input  logic                         cs1_n,
  input  logic                         cs2,
  input  logic                         cs3_n,
  input  logic                         we_n,
  input  logic                         adv,
  input  logic [AW-1:0]                addr,
  input  logic [NB-1:0]                ben_n,
  input  logic [NB*zt_pkg::LANE_W-1:0] din,
  input  logic                         oe_n,
  input  logic                         sleep,
  output logic [NB*zt_pkg::LANE_W-1:0] dout,
  output logic                         q_drive,
  output logic [NB-1:0]                par_err
);
  import zt_pkg::*;

  localparam int DW = NB * LANE_W;

  logic          cmd_vld, cmd_wr;
  logic [AW-1:0] cmd_addr;
  logic [NB-1:0] cmd_ben;

  // late-write pipeline
  logic          w1_vld, w2_vld;
  logic [AW-1:0] w1_addr, w2_addr;
  logic [NB-1:0] w1_ben, w2_ben;
  logic          c_vld;
  logic [AW-1:0] c_addr;
  logic [NB-1:0] c_ben;
  logic [DW-1:0] wst;

  // read pipeline
  logic          r1_vld, r2_vld;
  logic [AW-1:0] r1_addr;
  logic [NB-1:0] h0_mask;
  logic [DW-1:0] h0_data;
  logic [DW-1:0] rd_raw, ft_data, pl_next, pl_q;
  logic          rd_ok;

  zt_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
    .clk(clk), .rst(rst), .sleep(sleep), .adv(adv),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .we_n(we_n),
    .ilv(ilv_order), .addr_in(addr), .ben_n(ben_n),
    .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_ben(cmd_ben)
  );

  // the write whose data is on din at this edge
  assign c_vld  = pipe_mode ? w2_vld  : w1_vld;
  assign c_addr = pipe_mode ? w2_addr : w1_addr;
  assign c_ben  = pipe_mode ? w2_ben  : w1_ben;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam int LO = b * LANE_W;
    assign wst[LO +: LANE_W] = {din[LO+LANE_W-1] & ~byte8_mode, din[LO +: LANE_W-1]};

    zt_lane #(.AW(AW), .LW(LANE_W)) u_lane (
      .clk(clk), .we(c_vld & c_ben[b]), .waddr(c_addr),
      .wdata(wst[LO +: LANE_W]), .raddr(cmd_addr),
      .rdata(rd_raw[LO +: LANE_W])
    );

    assign ft_data[LO +: LANE_W] = h0_mask[b] ? h0_data[LO +: LANE_W]
                                              : rd_raw[LO +: LANE_W];
    assign pl_next[LO +: LANE_W] = (c_vld && c_ben[b] && (c_addr == r1_addr))
                                   ? wst[LO +: LANE_W] : ft_data[LO +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w1_vld  <= 1'b0;
      w2_vld  <= 1'b0;
      r1_vld  <= 1'b0;
      r2_vld  <= 1'b0;
      h0_mask <= '0;
    end else begin
      w1_vld  <= cmd_vld & cmd_wr;
      w2_vld  <= w1_vld;
      r1_vld  <= cmd_vld & ~cmd_wr;
      r2_vld  <= r1_vld;
      h0_mask <= (cmd_vld && !cmd_wr && c_vld && (c_addr == cmd_addr)) ? c_ben : '0;
    end
  end

  always_ff @(posedge clk) begin
    w1_addr <= cmd_addr;
    w1_ben  <= cmd_ben;
    w2_addr <= w1_addr;
    w2_ben  <= w1_ben;
    r1_addr <= cmd_addr;
    h0_data <= wst;
    if (r1_vld) pl_q <= pl_next;
  end

  zt_parity #(.NB(NB)) u_par (
    .clk(clk), .rst(rst), .chk_en(c_vld & ~byte8_mode), .odd(par_odd),
    .ben(c_ben), .data(din), .err(par_err)
  );

  assign rd_ok   = pipe_mode ? r2_vld : r1_vld;
  assign q_drive = rd_ok & ~oe_n & ~sleep;
  assign dout    = q_drive ? (pipe_mode ? pl_q : ft_data) : '0;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          oe_n,
  input logic          sleep,
  input logic          adv,
  input logic          cs1_n,
  input logic          cs2,
  input logic          cs3_n,
  input logic          byte8_mode,
  input logic          q_drive,
  input logic [NB-1:0] par_err,
  input logic          r1_vld,
  input logic          w1_vld,
  input logic          c_vld
);

  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !q_drive);

  // R9
  sleep_gate_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !q_drive);

  // R9
  sleep_noacc_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !(r1_vld || w1_vld));

  // R4
  desel_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !sleep && (cs1_n || !cs2 || cs3_n)) |=> !(r1_vld || w1_vld));

  // R10
  perr_src_chk: assert property (@(posedge clk) disable iff (rst)
    (par_err != '0) |-> $past(c_vld));

  // R11
  narrow_noerr_chk: assert property (@(posedge clk) disable iff (rst)
    (par_err != '0) |-> !$past(byte8_mode));

endmodule

bind zt_sram zt_sram_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst(rst), .oe_n(oe_n), .sleep(sleep), .adv(adv),
  .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .byte8_mode(byte8_mode),
  .q_drive(q_drive), .par_err(par_err),
  .r1_vld(r1_vld), .w1_vld(w1_vld), .c_vld(c_vld)
);

// File: tb/zt_sram_test.sv
module zt_sram_test;
  localparam int AW = 4;
  localparam int NB = 2;
  localparam int DW = NB * 9;
  localparam int MAXN = 160;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pipe_mode = 0, ilv_order = 0, byte8_mode = 0, par_odd = 0;
  logic cs1_n = 1, cs2 = 0, cs3_n = 1, we_n = 1, adv = 0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] ben_n = '1;
  logic [DW-1:0] din = '0;
  logic oe_n = 0, sleep = 0;
  logic [DW-1:0] dout;
  logic q_drive;
  logic [NB-1:0] par_err;

  zt_sram #(.AW(AW), .NB(NB)) uut (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .ilv_order(ilv_order),
    .byte8_mode(byte8_mode), .par_odd(par_odd), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .we_n(we_n), .adv(adv), .addr(addr), .ben_n(ben_n),
    .din(din), .oe_n(oe_n), .sleep(sleep), .dout(dout), .q_drive(q_drive),
    .par_err(par_err)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // program storage
  int n;
  logic p_c1n[MAXN], p_c2[MAXN], p_c3n[MAXN], p_wen[MAXN], p_adv[MAXN], p_slp[MAXN];
  logic [AW-1:0] p_a[MAXN];
  logic [NB-1:0] p_bn[MAXN];
  logic [DW-1:0] p_d[MAXN];
  logic e_drv[MAXN], e_oe[MAXN];
  logic [DW-1:0] e_dat[MAXN];
  logic [NB-1:0] e_perr[MAXN];
  string e_tag[MAXN];

  logic [DW-1:0] ref_mem[1<<AW];
  int salt = 0;
  bit b_act = 0, b_wr = 0;
  logic [AW-1:0] b_base = '0;
  logic [1:0] b_cnt = '0;

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return DW'(a * 4919) ^ DW'(s * 2731) ^ DW'(18'h2D96B);
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic put(input logic c1n, input logic c2, input logic c3n, input logic wen,
                     input logic ad, input logic slp, input logic [AW-1:0] a,
                     input logic [NB-1:0] bn, input logic [DW-1:0] d, input logic drv,
                     input logic oeoff, input logic [NB-1:0] perr, input string tag);
    p_c1n[n] = c1n; p_c2[n] = c2; p_c3n[n] = c3n; p_wen[n] = wen; p_adv[n] = ad;
    p_slp[n] = slp; p_a[n] = a; p_bn[n] = bn; p_d[n] = d;
    e_drv[n] = drv & ~oeoff; e_oe[n] = oeoff; e_perr[n] = perr; e_tag[n] = tag;
    e_dat[n] = (drv & ~oeoff) ? ref_mem[a] : '0;
    n++;
  endtask

  // apply a write to the reference; returns expected parity flags
  task automatic ref_write(input logic [AW-1:0] a, input logic [NB-1:0] bn,
                           input logic [DW-1:0] d, output logic [NB-1:0] perr);
    perr = '0;
    for (int b = 0; b < NB; b++) begin
      if (!bn[b]) begin
        ref_mem[a][b*9 +: 8] = d[b*9 +: 8];
        ref_mem[a][b*9+8]    = d[b*9+8] & ~byte8_mode;   // R11 bit 8 stored as zero
        if (!byte8_mode) perr[b] = (^d[b*9 +: 9]) ^ par_odd;   // R10
      end
    end
  endtask

  task automatic t_wr(input logic [AW-1:0] a, input logic [NB-1:0] bn, input string tag);
    logic [DW-1:0] d;
    logic [NB-1:0] pe;
    d = pat(a, salt++);
    ref_write(a, bn, d, pe);
    put(0, 1, 0, 0, 0, 0, a, bn, d, 0, 0, pe, tag);
    b_act = 1; b_wr = 1; b_base = a; b_cnt = 0;
  endtask

  task automatic t_rd(input logic [AW-1:0] a, input logic oeoff, input string tag);
    put(0, 1, 0, 1, 0, 0, a, '1, '0, 1, oeoff, '0, tag);
    b_act = 1; b_wr = 0; b_base = a; b_cnt = 0;
  endtask

  task automatic t_adv(input logic [NB-1:0] bn, input string tag);
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [NB-1:0] pe;
    b_cnt = b_cnt + 2'd1;
    a = b_base;
    a[1:0] = ilv_order ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt);   // R6 R7
    if (b_wr) begin
      d = pat(a, salt++);
      ref_write(a, bn, d, pe);
      put(1, 0, 1, 1, 1, 0, '0, bn, d, 0, 0, pe, tag);
    end else begin
      put(1, 0, 1, 0, 1, 0, a, '1, '0, 1, 0, '0, tag);
      p_a[n-1] = '0;
    end
  endtask

  // no access expected: deselect, stray advance or sleep
  task automatic t_none(input logic c1n, input logic c2, input logic c3n, input logic wen,
                        input logic ad, input logic slp, input logic [AW-1:0] a,
                        input string tag);
    put(c1n, c2, c3n, wen, ad, slp, a, '0, pat(a, salt++), 0, 0, '0, tag);
    if (!slp) b_act = 0;
  endtask

  task automatic build;
    string tb;
    n = 0;
    tb = ilv_order ? "R7" : "R6";
    for (int a = 0; a < 16; a++) t_wr(AW'(a), 2'b00, "R2");
    for (int a = 0; a < 16; a++) t_rd(AW'(a), 0, "R1");
    // R3 forwarding, back to back
    for (int k = 0; k < 2; k++) begin
      t_wr(AW'(3 + 4*k), 2'b10, "R5"); t_rd(AW'(3 + 4*k), 0, "R3");
      t_wr(AW'(3 + 4*k), 2'b01, "R5"); t_wr(AW'(3 + 4*k), 2'b11, "R5");
      t_rd(AW'(3 + 4*k), 0, "R3"); t_rd(AW'(3 + 4*k), 0, "R3");
    end
    t_wr(5, 2'b00, "R2"); t_none(1, 1, 0, 1, 0, 0, 0, "R4"); t_rd(5, 0, "R3");
    t_wr(9, 2'b00, "R2"); t_wr(9, 2'b10, "R5"); t_rd(9, 0, "R3");
    t_rd(10, 0, "R1"); t_wr(10, 2'b01, "R5"); t_rd(10, 0, "R3"); t_wr(11, 2'b00, "R2");
    t_rd(11, 0, "R3");
    // bursts
    t_wr(4'b0110, 2'b00, tb);
    for (int k = 0; k < 3; k++) t_adv(2'b00, tb);
    t_rd(4'b0110, 0, tb);
    for (int k = 0; k < 3; k++) t_adv('1, tb);
    t_rd(4'b1101, 0, tb);
    for (int k = 0; k < 4; k++) t_adv('1, tb);
    // R4 deselect
    t_none(1, 1, 0, 0, 0, 0, 2, "R4");
    t_none(0, 0, 0, 0, 0, 0, 2, "R4");
    t_none(0, 1, 1, 0, 0, 0, 2, "R4");
    t_none(0, 1, 1, 1, 0, 0, 2, "R4");
    t_none(0, 1, 0, 0, 1, 0, 2, "R6");   // advance with no burst
    t_rd(2, 0, "R4");
    // R9 sleep
    t_rd(3, 0, "R1");
    t_none(0, 1, 0, 0, 0, 1, 3, "R9");
    t_none(1, 1, 0, 1, 0, 0, 0, "R9");
    t_rd(3, 0, "R9");
    t_none(1, 1, 0, 1, 0, 0, 0, "R9");
    // R8 output enable
    t_rd(4, 1, "R8"); t_rd(4, 0, "R8");
  endtask

  task automatic run(input int lat);
    logic slp_prev;
    slp_prev = 0;
    for (int j = 0; j < n + lat + 3; j++) begin
      @(negedge clk);
      oe_n = (j - lat >= 0 && j - lat < n) ? e_oe[j-lat] : 1'b0;
      #1;
      if (j - lat >= 0 && j - lat < n) begin
        logic ed;
        ed = e_drv[j-lat] & ~slp_prev;
        check({e_tag[j-lat], " drive"}, DW'(q_drive), DW'(ed));
        check({e_tag[j-lat], " data"}, dout, ed ? e_dat[j-lat] : '0);
      end
      if (j - lat - 1 >= 0 && j - lat - 1 < n)
        check(byte8_mode ? "R11 parity" : "R10 parity", DW'(par_err), DW'(e_perr[j-lat-1]));
      if (j < n) begin
        cs1_n = p_c1n[j]; cs2 = p_c2[j]; cs3_n = p_c3n[j]; we_n = p_wen[j];
        adv = p_adv[j]; sleep = p_slp[j]; addr = p_a[j]; ben_n = p_bn[j];
      end else begin
        cs1_n = 1; cs2 = 0; cs3_n = 1; we_n = 1; adv = 0; sleep = 0;
      end
      din = (j - lat >= 0 && j - lat < n) ? p_d[j-lat] : '0;
      slp_prev = sleep;
    end
  endtask

  task automatic config_run(input logic pm, input logic il, input logic b8, input logic po);
    @(negedge clk);
    rst = 1; cs1_n = 1; cs2 = 0; cs3_n = 1; adv = 0; sleep = 0; oe_n = 0;
    pipe_mode = pm; ilv_order = il; byte8_mode = b8; par_odd = po;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check("R12 reset drive", DW'(q_drive), '0);
    check("R12 reset parity", DW'(par_err), '0);
    build();
    run(pm ? 2 : 1);
  endtask

  initial begin
    config_run(0, 0, 0, 0);
    config_run(1, 1, 0, 1);
    config_run(0, 1, 1, 0);
    config_run(1, 0, 1, 1);
    config_run(1, 1, 0, 0);
    config_run(0, 0, 0, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule